// File: doc/BRIEF.md
# Predicated Multi-Cycle 16-bit CPU Core

This block is a small multi-cycle processor core with a 16-bit datapath. It has four general registers, a flag register and a program counter. All six share one index space, so any instruction that can name a register can also read or write the flags or the program counter. Every instruction is a single 16-bit word. The one exception is the literal load, which takes one more word holding the literal. Every instruction carries a three-bit predicate. The core tests this predicate against three comparison flags, and when the test fails the instruction does nothing except move the program counter on.

The core reaches memory through one word-addressed port that makes one access at a time. The port has separate read and write strobes, an address, write data, and read data that is valid one cycle after a read strobe. The port also returns an error indication in that same cycle. The core does not decode addresses; an external bus decoder does that. The core stops for good, with its halt output raised, when it meets a predicate code that has no meaning or when the bus reports an error. Only reset releases it.

Each instruction passes through fetch, decode and execute states, plus a memory writeback state when it reads a literal or an operand from memory.

Top module: `pcpu_core`

## Requirements
- R1: After reset the program counter and the flag register are zero, the halt output is low, and the first read request is made at address 0.
- R2: Instruction fields are: opcode in bits 15:13, predicate in bits 12:10, source register index in bits 7:4, target register index in bits 3:0. Bits 9:8 have no effect.
- R3: Opcode 000 loads the word after the instruction into the target register. The program counter moves past both words whether or not the predicate holds. The literal word is read from memory only when the predicate holds.
- R4: Opcode 001 loads the memory word at the address held in the source register into the target register. Opcode 010 writes the source register to the memory address held in the target register.
- R5: Opcode 011 copies source to target. Opcode 100 writes source plus target, modulo 2^16, to target. Opcode 110 writes target AND source to target. Opcode 111 writes NOT source back to the source-field register.
- R6: Opcode 101 compares source against target as unsigned numbers. It leaves exactly one flag set: bit 0 when source is less, bit 1 when source is greater, bit 2 when they are equal. All other flag bits are cleared.
- R7: Predicate codes: 000 never, 001 when bit 0 or bit 1 of the flags is set, 010 when bit 2 is set, 011 when bit 0 is set, 100 when bit 1 is set, 111 always.
- R8: An instruction whose predicate fails changes no register, no flag and no memory. The program counter still advances by one, or by two for opcode 000.
- R9: Index 4 is the flag register and index 5 is the program counter. When an instruction writes the value V to index 5, the next fetch is from V+1.
- R10: Register indices 6 to 15 read as zero, ignore writes, and do not cause a halt.
- R11: Predicate codes 101 and 110 raise the halt output. The instruction has no side effect. Halt stays high and no further memory request is made until reset.
- R12: A bus error reported with the data of any read raises the halt output. The data returned with the error is discarded and no register is written.
- R13: At most one of the read and write strobes is high in any cycle. Read data is taken in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd | output | 1 | Read request for the current cycle |
| mem_wr | output | 1 | Write request for the current cycle |
| mem_addr | output | 16 | Word address of the request |
| mem_wdata | output | 16 | Data to be written |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| mem_err | input | 1 | Bus error, valid the cycle after mem_rd |
| halted | output | 1 | Sticky halt/error indication |

## Verification
A wrong program counter appears within one instruction as a fetch from the wrong address. The test programs are laid out so that any such fetch lands on a halting word or misses a store, so the log of stores comes out short or in the wrong order. A wrong register or flag value shows up at the next store that copies that register, or the flags moved into a register, out to memory. The programs store after every operation, so an error surfaces within a few instructions. A broken predicate or a broken sticky halt shows at once: a store appears that should be absent, or a bus request is made while halt is high.

// File: rtl/pcpu_pkg.sv
package pcpu_pkg;

    typedef enum logic [2:0] {
        OP_LIT   = 3'b000,
        OP_LOAD  = 3'b001,
        OP_STORE = 3'b010,
        OP_MOVE  = 3'b011,
        OP_ADD   = 3'b100,
        OP_CMP   = 3'b101,
        OP_AND   = 3'b110,
        OP_NOT   = 3'b111
    } opcode_e;

    typedef enum logic [2:0] {
        PR_NEVER  = 3'b000,
        PR_NE     = 3'b001,
        PR_EQ     = 3'b010,
        PR_LT     = 3'b011,
        PR_GT     = 3'b100,
        PR_BAD5   = 3'b101,
        PR_BAD6   = 3'b110,
        PR_ALWAYS = 3'b111
    } pred_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_WB,
        ST_HALT
    } state_e;

    localparam int FLG_LT = 0;
    localparam int FLG_GT = 1;
    localparam int FLG_EQ = 2;
    localparam int FLG_W  = 3;

endpackage

// File: rtl/pcpu_pred.sv
module pcpu_pred
    import pcpu_pkg::*;
(
    input  pred_e            code,
    input  logic [FLG_W-1:0] flags,
    output logic             hit,
    output logic             bad
);

    always_comb begin
        hit = 1'b0;
        bad = 1'b0;
        case (code)
            PR_NEVER:  hit = 1'b0;
            PR_NE:     hit = flags[FLG_LT] | flags[FLG_GT];
            PR_EQ:     hit = flags[FLG_EQ];
            PR_LT:     hit = flags[FLG_LT];
            PR_GT:     hit = flags[FLG_GT];
            PR_ALWAYS: hit = 1'b1;
            default:   bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/pcpu_alu.sv
module pcpu_alu
    import pcpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_e            op,
    input  logic [DATA_W-1:0]  src,
    input  logic [DATA_W-1:0]  tgt,
    output logic [DATA_W-1:0]  res,
    output logic [FLG_W-1:0]   cmp_flags
);

    always_comb begin
        case (op)
            OP_ADD:  res = src + tgt;
            OP_AND:  res = tgt & src;
            OP_NOT:  res = ~src;
            default: res = src;
        endcase
    end

    always_comb begin
        cmp_flags         = '0;
        cmp_flags[FLG_LT] = (src < tgt);
        cmp_flags[FLG_GT] = (src > tgt);
        cmp_flags[FLG_EQ] = (src == tgt);
    end

endmodule

// File: rtl/pcpu_gpr.sv
module pcpu_gpr #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4,
    parameter int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  rsel_a,
    input  logic [SEL_W-1:0]  rsel_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [NUM_REGS-1:0]             hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] file_d;
    logic [NUM_REGS-1:0][DATA_W-1:0] file_q;

    generate
        for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_dec
            assign hit[gi] = we && (wsel == SEL_W'(gi));
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            file_d[i] = hit[i] ? wdata : file_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) file_q <= '0;
        else        file_q <= file_d;
    end

    assign rdata_a = file_q[rsel_a];
    assign rdata_b = file_q[rsel_b];

endmodule

// File: rtl/pcpu_core.sv
module pcpu_core
    import pcpu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_GPR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              halted
);

    localparam int IDX_W    = 4;
    localparam int FLAG_IDX = NUM_GPR;
    localparam int PC_IDX   = NUM_GPR + 1;
    localparam int GSEL_W   = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    localparam logic [DATA_W-1:0] TWO = DATA_W'(2);

    typedef struct packed {
        state_e            st;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] flg;
        logic [DATA_W-1:0] ir;
        logic              halt;
    } core_t;

    core_t core_d, core_q;

    // Instruction fields
    opcode_e          op;
    pred_e            pcode;
    logic [IDX_W-1:0] src_idx;
    logic [IDX_W-1:0] tgt_idx;
    logic             unused_ir;

    assign op        = opcode_e'(core_q.ir[15:13]);
    assign pcode     = pred_e'(core_q.ir[12:10]);
    assign src_idx   = core_q.ir[7:4];
    assign tgt_idx   = core_q.ir[3:0];
    assign unused_ir = ^core_q.ir[9:8];

    // Submodules
    logic              pr_hit, pr_bad;
    logic [DATA_W-1:0] gpr_src, gpr_tgt;
    logic [DATA_W-1:0] src_val, tgt_val;
    logic [DATA_W-1:0] alu_res;
    logic [FLG_W-1:0]  alu_flags;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_val;
    logic              gpr_we;

    pcpu_pred u_pred (
        .code  (pcode),
        .flags (core_q.flg[FLG_W-1:0]),
        .hit   (pr_hit),
        .bad   (pr_bad)
    );

    pcpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op        (op),
        .src       (src_val),
        .tgt       (tgt_val),
        .res       (alu_res),
        .cmp_flags (alu_flags)
    );

    pcpu_gpr #(.DATA_W(DATA_W), .NUM_REGS(NUM_GPR), .SEL_W(GSEL_W)) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (gpr_we),
        .wsel    (wr_idx[GSEL_W-1:0]),
        .wdata   (wr_val),
        .rsel_a  (src_idx[GSEL_W-1:0]),
        .rsel_b  (tgt_idx[GSEL_W-1:0]),
        .rdata_a (gpr_src),
        .rdata_b (gpr_tgt)
    );

    // Register index space: GPRs, then flags, then PC, rest read zero
    always_comb begin
        if (src_idx < IDX_W'(NUM_GPR))        src_val = gpr_src;
        else if (src_idx == IDX_W'(FLAG_IDX)) src_val = core_q.flg;
        else if (src_idx == IDX_W'(PC_IDX))   src_val = core_q.pc;
        else                                  src_val = '0;

        if (tgt_idx < IDX_W'(NUM_GPR))        tgt_val = gpr_tgt;
        else if (tgt_idx == IDX_W'(FLAG_IDX)) tgt_val = core_q.flg;
        else if (tgt_idx == IDX_W'(PC_IDX))   tgt_val = core_q.pc;
        else                                  tgt_val = '0;
    end

    // Next-state logic
    always_comb begin
        core_d    = core_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = core_q.pc;
        mem_wdata = '0;
        wr_en     = 1'b0;
        wr_idx    = tgt_idx;
        wr_val    = alu_res;

        case (core_q.st)
            ST_FETCH: begin
                mem_rd    = 1'b1;
                mem_addr  = core_q.pc;
                core_d.st = ST_DECODE;
            end

            ST_DECODE: begin
                if (mem_err) begin
                    core_d.halt = 1'b1;
                    core_d.st   = ST_HALT;
                end else begin
                    core_d.ir = mem_rdata;
                    core_d.st = ST_EXEC;
                end
            end

            ST_EXEC: begin
                if (pr_bad) begin
                    core_d.halt = 1'b1;
                    core_d.st   = ST_HALT;
                end else begin
                    core_d.pc = core_q.pc + ONE;
                    core_d.st = ST_FETCH;
                    case (op)
                        OP_LIT: begin
                            if (pr_hit) begin
                                mem_rd    = 1'b1;
                                mem_addr  = core_q.pc + ONE;
                                core_d.st = ST_WB;
                            end else begin
                                core_d.pc = core_q.pc + TWO;
                            end
                        end
                        OP_LOAD: begin
                            if (pr_hit) begin
                                mem_rd    = 1'b1;
                                mem_addr  = src_val;
                                core_d.pc = core_q.pc;
                                core_d.st = ST_WB;
                            end
                        end
                        OP_STORE: begin
                            if (pr_hit) begin
                                mem_wr    = 1'b1;
                                mem_addr  = tgt_val;
                                mem_wdata = src_val;
                            end
                        end
                        OP_CMP: begin
                            if (pr_hit) core_d.flg = {{(DATA_W-FLG_W){1'b0}}, alu_flags};
                        end
                        OP_NOT: begin
                            wr_en  = pr_hit;
                            wr_idx = src_idx;
                        end
                        default: begin
                            wr_en = pr_hit;
                        end
                    endcase
                end
            end

            ST_WB: begin
                if (mem_err) begin
                    core_d.halt = 1'b1;
                    core_d.st   = ST_HALT;
                end else begin
                    wr_en     = 1'b1;
                    wr_val    = mem_rdata;
                    core_d.pc = core_q.pc + ONE;
                    core_d.st = ST_FETCH;
                end
            end

            default: begin
                core_d.st = ST_HALT;
            end
        endcase

        // Central write routing; PC writes get the post-increment
        if (wr_en) begin
            if (wr_idx == IDX_W'(PC_IDX))        core_d.pc  = wr_val + ONE;
            else if (wr_idx == IDX_W'(FLAG_IDX)) core_d.flg = wr_val;
        end
        gpr_we = wr_en && (wr_idx < IDX_W'(NUM_GPR));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '{st: ST_FETCH, pc: '0, flg: '0, ir: '0, halt: 1'b0};
        end else begin
            core_q <= core_d;
        end
    end

    assign halted = core_q.halt;

    // Assertions
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R11
    AST_QUIET_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr)); // R11
    AST_ILLEGAL_PRED_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_EXEC && pr_bad) |=> halted); // R11
    AST_BUS_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_q.st == ST_DECODE || core_q.st == ST_WB) && mem_err) |=> halted); // R12
    AST_SINGLE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R13
    AST_CMP_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_EXEC && op == OP_CMP && pr_hit && !pr_bad)
        |=> ($countones(core_q.flg) == 1)); // R6
    AST_FAILED_PRED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_EXEC && !pr_hit) |-> !mem_wr); // R8
    AST_FAILED_PRED_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_EXEC && !pr_hit && !pr_bad)
        |=> (core_q.pc == $past(core_q.pc) + (($past(op) == OP_LIT) ? TWO : ONE))); // R8

endmodule

// File: tb/pcpu_core_tb.sv
`timescale 1ns/1ps
module pcpu_core_tb;

    localparam logic [2:0] O_LIT = 3'b000, O_LD = 3'b001, O_ST = 3'b010, O_MOV = 3'b011;
    localparam logic [2:0] O_ADD = 3'b100, O_CMP = 3'b101, O_AND = 3'b110, O_NOT = 3'b111;
    localparam logic [2:0] P_NV = 3'b000, P_GT = 3'b100, P_AL = 3'b111;
    localparam logic [2:0] P_BAD5 = 3'b101, P_BAD6 = 3'b110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd, mem_wr, mem_err, halted;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    pcpu_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_err   (mem_err),
        .halted    (halted)
    );

    // Memory model with store log
    logic [15:0] mem [0:1023];
    logic        ld_we = 1'b0;
    logic [9:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        log_clr = 1'b0;
    logic        err_en = 1'b0;
    logic [15:0] err_addr = '0;
    logic [15:0] probe_addr = 16'hFFFF;
    logic [15:0] log_addr [0:31];
    logic [15:0] log_data [0:31];
    int          log_n = 0;
    int          probe_hits = 0;
    int          quiet_viol = 0;
    int          both_viol = 0;

    always @(posedge clk) begin
        mem_err <= 1'b0;
        if (ld_we) mem[ld_addr] <= ld_data;
        if (log_clr) begin
            log_n      <= 0;
            probe_hits <= 0;
            quiet_viol <= 0;
            both_viol  <= 0;
        end else begin
            if (halted && (mem_rd || mem_wr)) quiet_viol <= quiet_viol + 1;
            if (mem_rd && mem_wr) both_viol <= both_viol + 1;
            if (mem_rd && mem_addr == probe_addr) probe_hits <= probe_hits + 1;
            if (mem_wr && log_n < 32) begin
                log_addr[log_n] <= mem_addr;
                log_data[log_n] <= mem_wdata;
                log_n           <= log_n + 1;
            end
        end
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[9:0]];
            if (err_en && mem_addr == err_addr) mem_err <= 1'b1;
        end
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
    end

    // Checking
    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic chk_log(input string tag, input int k, input logic [15:0] exp);
        if (k < log_n) chk_eq(tag, log_data[k], exp);
        else chk(1'b0, tag, 16'hxxxx, exp);
    endtask

    // Program builder
    logic [15:0] pw [0:127];
    logic [15:0] pa [0:127];
    int pn = 0;
    int cur_ad = 0;

    function automatic logic [15:0] iw(input logic [2:0] op, input logic [2:0] pr,
                                       input logic [3:0] s, input logic [3:0] t);
        return {op, pr, 2'b00, s, t};
    endfunction

    task automatic emit_at(input int a, input logic [15:0] w);
        pa[pn] = 16'(a);
        pw[pn] = w;
        pn++;
    endtask

    task automatic emit(input logic [15:0] w);
        emit_at(cur_ad, w);
        cur_ad++;
    endtask

    task automatic start_prog();
        pn = 0;
        cur_ad = 0;
    endtask

    task automatic run_prog();
        int cyc;
        rst_n = 1'b0;
        @(negedge clk);
        log_clr = 1'b1;
        for (int k = 0; k < pn; k++) begin
            ld_we   = 1'b1;
            ld_addr = pa[k][9:0];
            ld_data = pw[k];
            @(negedge clk);
        end
        ld_we = 1'b0;
        @(negedge clk);
        log_clr = 1'b0;
        rst_n   = 1'b1;
        cyc = 0;
        while (!halted && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [15:0] flag_exp(input logic [15:0] a, input logic [15:0] b);
        if (a < b) return 16'h0001;
        if (a > b) return 16'h0002;
        return 16'h0004;
    endfunction

    function automatic bit pred_exp(input logic [2:0] p, input logic [15:0] f);
        case (p)
            3'b000:  return 1'b0;
            3'b001:  return f[0] | f[1];
            3'b010:  return f[2];
            3'b011:  return f[0];
            3'b100:  return f[1];
            default: return 1'b1;
        endcase
    endfunction

    task automatic build_arith(input logic [15:0] a, input logic [15:0] b, input logic [2:0] endp);
        logic [2:0] plist [0:5];
        plist = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b111};
        start_prog();
        emit(iw(O_LIT, P_AL, 0, 0)); emit(a);
        emit(iw(O_LIT, P_AL, 0, 1)); emit(b);
        emit(iw(O_MOV, P_AL, 1, 2));
        emit(iw(O_ADD, P_AL, 0, 2));
        emit(iw(O_LIT, P_AL, 0, 3)); emit(16'h0300);
        emit(iw(O_ST,  P_AL, 2, 3));
        emit(iw(O_MOV, P_AL, 1, 2));
        emit(iw(O_AND, P_AL, 0, 2));
        emit(iw(O_ST,  P_AL, 2, 3));
        emit(iw(O_MOV, P_AL, 0, 2));
        emit(iw(O_NOT, P_AL, 2, 0));
        emit(iw(O_ST,  P_AL, 2, 3));
        emit(iw(O_CMP, P_AL, 0, 1));
        emit(iw(O_MOV, P_AL, 4, 2));
        emit(iw(O_ST,  P_AL, 2, 3));
        for (int i = 0; i < 6; i++) begin
            emit(iw(O_LIT, P_AL, 0, 2)); emit(16'h0000);
            emit(iw(O_LIT, plist[i], 0, 2)); emit(16'h1000 + 16'(plist[i]));
            emit(iw(O_ST,  P_AL, 2, 3));
        end
        emit(iw(O_ST,  P_NV, 0, 3));
        emit(iw(O_CMP, P_NV, 1, 0));
        emit(iw(O_MOV, P_AL, 4, 2));
        emit(iw(O_ST,  P_AL, 2, 3));
        emit(iw(O_LIT, endp, 0, 0));
    endtask

    task automatic check_arith(input logic [15:0] a, input logic [15:0] b);
        logic [2:0]  plist [0:5];
        logic [15:0] f;
        plist = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b111};
        f = flag_exp(a, b);
        chk_eq("R11 halt after illegal predicate", {15'd0, halted}, 16'd1);
        chk_eq("R8 store count (failed store absent)", 16'(log_n), 16'd11);
        chk_log("R5 add wraps", 0, a + b);
        chk_log("R5 and", 1, a & b);
        chk_log("R5 not writes source field", 2, ~a);
        chk_log("R6 compare flags", 3, f);
        for (int i = 0; i < 6; i++) begin
            chk_log("R7 predicated literal", 4 + i,
                    pred_exp(plist[i], f) ? (16'h1000 + 16'(plist[i])) : 16'h0000);
        end
        chk_log("R8 failed compare keeps flags", 10, f);
        chk_eq("R4 store address", (log_n > 0) ? log_addr[0] : 16'hxxxx, 16'h0300);
        chk_eq("R11 no bus request while halted", 16'(quiet_viol), 16'd0);
        chk_eq("R13 never read and write together", 16'(both_viol), 16'd0);
    endtask

    // Watchdog
    initial begin
        #1500000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] vals [0:7];
        vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'h00FF, 16'h8001};

        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R1 halt low in reset", {15'd0, halted}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk_eq("R1 first fetch request", {15'd0, mem_rd}, 16'd1);
        chk_eq("R1 first fetch address", mem_addr, 16'h0000);

        // Arithmetic, compare and predicate sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                build_arith(vals[i], vals[j], ((i + j) % 2 == 0) ? P_BAD5 : P_BAD6);
                run_prog();
                check_arith(vals[i], vals[j]);
            end
        end

        // Flags after reset, and a literal word skipped on failed predicate
        start_prog();
        probe_addr = 16'h0001;
        emit(iw(O_LIT, P_NV, 0, 0)); emit(16'h5555);
        emit(iw(O_LIT, P_AL, 0, 3)); emit(16'h0300);
        emit(iw(O_MOV, P_AL, 4, 2));
        emit(iw(O_ST,  P_AL, 2, 3));
        emit(iw(O_MOV, P_AL, 0, 2));
        emit(iw(O_ST,  P_AL, 2, 3));
        emit(iw(O_LIT, P_BAD6, 0, 0));
        run_prog();
        chk_eq("R1 flags zero after reset", log_data[0], 16'h0000);
        chk_eq("R3 literal not read on failed predicate", 16'(probe_hits), 16'd0);
        chk_eq("R3 target untouched by failed literal", log_data[1], 16'h0000);
        chk_eq("R3 pc skips literal word", 16'(log_n), 16'd2);
        probe_addr = 16'hFFFF;

        // Jumps, special indices, loads
        start_prog();
        emit_at(16'h00, iw(O_LIT, P_AL, 0, 5)); emit_at(16'h01, 16'h000F);
        emit_at(16'h02, iw(O_LIT, P_BAD5, 0, 0));
        emit_at(16'h10, iw(O_LIT, P_AL, 0, 3)); emit_at(16'h11, 16'h0300);
        emit_at(16'h12, iw(O_MOV, P_AL, 5, 0));
        emit_at(16'h13, iw(O_ST,  P_AL, 0, 3));
        emit_at(16'h14, iw(O_LIT, P_AL, 0, 2)); emit_at(16'h15, 16'h001F);
        emit_at(16'h16, iw(O_MOV, P_AL, 2, 5));
        emit_at(16'h17, iw(O_LIT, P_BAD5, 0, 0));
        emit_at(16'h20, iw(O_LIT, P_AL, 0, 1)); emit_at(16'h21, 16'h0003);
        emit_at(16'h22, iw(O_ADD, P_AL, 1, 5));
        emit_at(16'h23, iw(O_LIT, P_BAD5, 0, 0));
        emit_at(16'h24, iw(O_LIT, P_BAD5, 0, 0));
        emit_at(16'h25, iw(O_LIT, P_BAD5, 0, 0));
        emit_at(16'h26, iw(O_ST,  P_AL, 1, 3));
        emit_at(16'h27, iw(O_CMP, P_AL, 0, 1));
        emit_at(16'h28, iw(O_LIT, P_GT, 0, 5)); emit_at(16'h29, 16'h002F);
        emit_at(16'h2A, iw(O_LIT, P_BAD5, 0, 0));
        emit_at(16'h30, iw(O_LIT, P_AL, 0, 2)); emit_at(16'h31, 16'h0007);
        emit_at(16'h32, iw(O_MOV, P_AL, 2, 4));
        emit_at(16'h33, iw(O_MOV, P_AL, 4, 0));
        emit_at(16'h34, iw(O_ST,  P_AL, 0, 3));
        emit_at(16'h35, iw(O_LIT, P_AL, 0, 2)); emit_at(16'h36, 16'h1234);
        emit_at(16'h37, iw(O_MOV, P_AL, 2, 9));
        emit_at(16'h38, iw(O_MOV, P_AL, 9, 2));
        emit_at(16'h39, iw(O_ST,  P_AL, 2, 3));
        emit_at(16'h3A, iw(O_LIT, P_AL, 0, 0)); emit_at(16'h3B, 16'h00AB);
        emit_at(16'h3C, iw(O_ADD, P_AL, 0, 12));
        emit_at(16'h3D, iw(O_MOV, P_AL, 12, 1));
        emit_at(16'h3E, iw(O_ST,  P_AL, 1, 3));
        emit_at(16'h3F, iw(O_LIT, P_AL, 0, 1)); emit_at(16'h40, 16'h0100);
        emit_at(16'h41, iw(O_LD,  P_AL, 1, 2));
        emit_at(16'h42, iw(O_ST,  P_AL, 2, 3));
        emit_at(16'h43, iw(O_LIT, P_AL, 0, 1)); emit_at(16'h44, 16'h0101);
        emit_at(16'h45, iw(O_LD,  P_AL, 1, 5));
        emit_at(16'h46, iw(O_LIT, P_BAD5, 0, 0));
        emit_at(16'h50, iw(O_LIT, P_AL, 0, 2)); emit_at(16'h51, 16'h0077);
        emit_at(16'h52, iw(O_ST,  P_AL, 2, 3));
        emit_at(16'h53, {O_MOV, P_AL, 2'b11, 4'd2, 4'd0});
        emit_at(16'h54, iw(O_ST,  P_AL, 0, 3));
        emit_at(16'h55, iw(O_LIT, P_BAD6, 0, 0));
        emit_at(16'h100, 16'hC0DE);
        emit_at(16'h101, 16'h004F);
        run_prog();
        chk_eq("R9 store count along jump path", 16'(log_n), 16'd8);
        chk_log("R9 literal write to PC then read of PC", 0, 16'h0012);
        chk_log("R9 add into PC lands at sum plus one", 1, 16'h0003);
        chk_log("R9 flag register written through index 4", 2, 16'h0007);
        chk_log("R10 index 9 reads zero after write", 3, 16'h0000);
        chk_log("R10 index 12 reads zero after add", 4, 16'h0000);
        chk_log("R4 load from memory", 5, 16'hC0DE);
        chk_log("R4 load into PC jumps", 6, 16'h0077);
        chk_log("R2 bits 9:8 ignored", 7, 16'h0077);
        chk_eq("R11 halted on code 110", {15'd0, halted}, 16'd1);

        // Bus error on an operand read
        start_prog();
        emit(iw(O_LIT, P_AL, 0, 1)); emit(16'h0100);
        emit(iw(O_LD,  P_AL, 1, 2));
        emit(iw(O_LIT, P_AL, 0, 3)); emit(16'h0300);
        emit(iw(O_ST,  P_AL, 2, 3));
        emit(iw(O_LIT, P_BAD5, 0, 0));
        err_en   = 1'b1;
        err_addr = 16'h0100;
        run_prog();
        err_en = 1'b0;
        chk_eq("R12 halt on bus error", {15'd0, halted}, 16'd1);
        chk_eq("R12 no store after bus error", 16'(log_n), 16'd0);
        chk_eq("R12 quiet bus after error halt", 16'(quiet_viol), 16'd0);

        // Reset releases the halt
        rst_n = 1'b0;
        @(negedge clk);
        chk_eq("R11 reset clears halt", {15'd0, halted}, 16'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule